// File: doc/BRIEF.md
# Serial ADC Host Readout Controller

This block sits on the host side of a four-wire serial link to a delta-sigma converter that is run with the host's clock. The converter runs one conversion at a time. A caller hands the block a 6-bit channel configuration through a ready/valid start port. The block then lowers chip select while holding the serial clock low, so the converter stays in externally clocked mode. It watches the converter's data line as a level: the line is high while a conversion is still running and low once a result is waiting.

When the line reads low, the block issues 24 serial clock pulses. On the data-in line it sends an 8-bit command: a fixed `1`, `0` header, then the configuration, then 16 zero bits. On every rising edge it samples the data-out line. After the 24th falling edge it raises chip select, so the converter can start the next conversion in its low-power state. It then presents the result on a ready/valid output port.

The converter uses the channel carried in a transfer for the conversion that follows that transfer. For this reason, each result is tagged with the configuration sent in the previous completed transfer. A runtime divider sets the length of each clock half-period. A runtime poll limit bounds how long the block waits for a result before it gives up and releases chip select.

Top module: `adc_readout_host`

## Requirements
- R1: After reset, csN is 1, sck is 0, resValid is 0 and startReady is 1.
- R2: csN only falls while sck is 0, and sck is 1 only while csN is 0.
- R3: After chip select falls, sck stays low as long as sdo is sampled high. If sdo is sampled high on pollLimit consecutive cycles (a value of 0 counts as 1), errTimeout pulses for one cycle. csN then returns to 1 after exactly pollLimit cycles low, and no result is produced.
- R4: While clocking, every sck high phase, and every low phase between two rising edges, lasts max(halfDiv,1) clock cycles.
- R5: A transfer has exactly 24 rising sck edges. sdi carries, MSB first, `1`, `0`, startCfg[5:0], then 16 zeros. The startCfg field layout is [5]=enable, [4]=single-ended, [3]=odd/polarity, [2:0]=channel address.
- R6: sdo is sampled on each rising sck edge, MSB first, into a 24-bit frame. resSign reports frame bit 21 and resData reports frame bits 20..0.
- R7: resCfg is the startCfg of the previous transfer that completed (0 after reset). A timed-out attempt does not count as a completed transfer.
- R8: resFrameErr is 1 exactly when frame bit 23 or frame bit 22 was sampled as 1.
- R9: csN returns to 1 one clock after the 24th falling sck edge, on the same edge where resValid rises.
- R10: resValid and the result fields hold until resReady is seen high. startReady is 0 while a transfer runs or while a result is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start request |
| startReady | output | 1 | Start request accepted when high |
| startCfg | input | 6 | Channel configuration for this transfer |
| halfDiv | input | DIV_W | SCK half-period in clock cycles (0 acts as 1) |
| pollLimit | input | POLL_W | Maximum busy samples before timeout (0 acts as 1) |
| csN | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock |
| sdi | output | 1 | Command bits to the converter |
| sdo | input | 1 | Ready level, then frame bits, from the converter |
| resValid | output | 1 | Result available |
| resReady | input | 1 | Result consumed when high with resValid |
| resData | output | 21 | Frame bits 20..0 |
| resSign | output | 1 | Frame bit 21 |
| resCfg | output | 6 | Configuration that selected this result |
| resFrameErr | output | 1 | Header bit 23 or 22 was nonzero |
| errTimeout | output | 1 | One-cycle pulse on poll timeout |

## Verification
The assertions assume that halfDiv and pollLimit stay constant while a transfer is in flight, and that sdo changes only between system clock edges, never in the same edge as the sampling. The bench changes the divider and poll limit only while startReady is high. Its converter model updates sdo from events on sck and chip select, so each new level settles well before the next clock edge. The model never clocks out data unless its conversion is finished, and it reports any rising sck edge seen while it is still busy.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

  localparam int FRAME_BITS = 24;
  localparam int CFG_BITS   = 6;
  localparam int DATA_BITS  = FRAME_BITS - 3;
  localparam int CNT_BITS   = $clog2(FRAME_BITS + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL,
    ST_LOW,
    ST_HIGH,
    ST_END
  } ctrlState_t;

  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic sampleRx;
    logic publish;
  } adcrdStrobe_t;

endpackage

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
  import adcrd_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  output logic              startReady,
  input  logic [DIV_W-1:0]  halfDiv,
  input  logic [POLL_W-1:0] pollLimit,
  input  logic              sdo,
  input  logic              resValid,
  output logic              csN,
  output logic              sck,
  output logic              errTimeout,
  output adcrdStrobe_t      strobe
);

  localparam logic [CNT_BITS-1:0] LAST_FALL = CNT_BITS'(FRAME_BITS - 1);

  ctrlState_t        state;
  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  effDiv;
  logic [POLL_W-1:0] pollCnt;
  logic [POLL_W-1:0] effLimit;
  logic [CNT_BITS-1:0] bitCnt;
  logic              phaseEnd;

  assign effDiv   = (halfDiv == '0) ? DIV_W'(1) : halfDiv;
  assign effLimit = (pollLimit == '0) ? POLL_W'(1) : pollLimit;
  assign phaseEnd = (divCnt == effDiv);

  assign startReady = (state == ST_IDLE) && !resValid;

  always_comb begin
    strobe          = '0;
    strobe.loadTx   = startValid && startReady;
    strobe.sampleRx = (state == ST_LOW) && phaseEnd;
    strobe.shiftTx  = (state == ST_HIGH) && phaseEnd;
    strobe.publish  = (state == ST_END);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      csN        <= 1'b1;
      sck        <= 1'b0;
      divCnt     <= '0;
      pollCnt    <= '0;
      bitCnt     <= '0;
      errTimeout <= 1'b0;
    end else begin
      errTimeout <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (startValid && startReady) begin
            state   <= ST_POLL;
            csN     <= 1'b0;
            pollCnt <= '0;
            bitCnt  <= '0;
          end
        end
        ST_POLL: begin
          if (!sdo) begin
            state  <= ST_LOW;
            divCnt <= DIV_W'(1);
          end else if (pollCnt + 1'b1 == effLimit) begin
            state      <= ST_IDLE;
            csN        <= 1'b1;
            errTimeout <= 1'b1;
          end else begin
            pollCnt <= pollCnt + 1'b1;
          end
        end
        ST_LOW: begin
          if (phaseEnd) begin
            state  <= ST_HIGH;
            sck    <= 1'b1;
            divCnt <= DIV_W'(1);
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (phaseEnd) begin
            sck    <= 1'b0;
            divCnt <= DIV_W'(1);
            bitCnt <= bitCnt + 1'b1;
            state  <= (bitCnt == LAST_FALL) ? ST_END : ST_LOW;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_END: begin
          state <= ST_IDLE;
          csN   <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checker state: length of the current sck high run
  logic [DIV_W:0] highLen;
  always_ff @(posedge clk) begin
    if (!rstN)    highLen <= '0;
    else if (sck) highLen <= highLen + 1'b1;
    else          highLen <= '0;
  end

  assert_cs_fall_sck_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> !sck);

  assert_sck_within_cs_R2: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> !csN);

  assert_no_clock_while_polling_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_POLL) |-> !sck);

  assert_high_phase_len_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sck) |-> (highLen == {1'b0, effDiv}));

  assert_full_frame_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(csN) && !errTimeout) |-> (bitCnt == CNT_BITS'(FRAME_BITS)));

  assert_timeout_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    errTimeout |-> (csN && !sck && !resValid));

endmodule

// File: rtl/adcrd_datapath.sv
module adcrd_datapath
  import adcrd_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  adcrdStrobe_t        strobe,
  input  logic [CFG_BITS-1:0] startCfg,
  input  logic                sdo,
  input  logic                resReady,
  output logic                sdi,
  output logic                resValid,
  output logic [DATA_BITS-1:0] resData,
  output logic                resSign,
  output logic [CFG_BITS-1:0] resCfg,
  output logic                resFrameErr
);

  localparam int PAD_BITS = FRAME_BITS - CFG_BITS - 2;

  logic [FRAME_BITS-1:0] txReg;
  logic [FRAME_BITS-1:0] rxReg;
  logic [CFG_BITS-1:0]   curCfg;
  logic [CFG_BITS-1:0]   prevCfg;

  assign sdi = txReg[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txReg  <= '0;
      rxReg  <= '0;
      curCfg <= '0;
    end else begin
      if (strobe.loadTx) begin
        txReg  <= {2'b10, startCfg, {PAD_BITS{1'b0}}};
        curCfg <= startCfg;
      end else if (strobe.shiftTx) begin
        txReg <= {txReg[FRAME_BITS-2:0], 1'b0};
      end
      if (strobe.sampleRx) rxReg <= {rxReg[FRAME_BITS-2:0], sdo};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid    <= 1'b0;
      resData     <= '0;
      resSign     <= 1'b0;
      resCfg      <= '0;
      resFrameErr <= 1'b0;
      prevCfg     <= '0;
    end else if (strobe.publish) begin
      resValid    <= 1'b1;
      resData     <= rxReg[DATA_BITS-1:0];
      resSign     <= rxReg[DATA_BITS];
      resFrameErr <= rxReg[FRAME_BITS-1] | rxReg[FRAME_BITS-2];
      resCfg      <= prevCfg;
      prevCfg     <= curCfg;
    end else if (resValid && resReady) begin
      resValid <= 1'b0;
    end
  end

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resReady) |=> (resValid && $stable(resData) && $stable(resCfg)));

  assert_publish_idle_line_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.publish |-> !sdi);

endmodule

// File: rtl/adc_readout_host.sv
module adc_readout_host
  import adcrd_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int POLL_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startValid,
  output logic                 startReady,
  input  logic [CFG_BITS-1:0]  startCfg,
  input  logic [DIV_W-1:0]     halfDiv,
  input  logic [POLL_W-1:0]    pollLimit,
  output logic                 csN,
  output logic                 sck,
  output logic                 sdi,
  input  logic                 sdo,
  output logic                 resValid,
  input  logic                 resReady,
  output logic [DATA_BITS-1:0] resData,
  output logic                 resSign,
  output logic [CFG_BITS-1:0]  resCfg,
  output logic                 resFrameErr,
  output logic                 errTimeout
);

  adcrdStrobe_t strobe;

  adcrd_ctrl #(.DIV_W(DIV_W), .POLL_W(POLL_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .startReady (startReady),
    .halfDiv    (halfDiv),
    .pollLimit  (pollLimit),
    .sdo        (sdo),
    .resValid   (resValid),
    .csN        (csN),
    .sck        (sck),
    .errTimeout (errTimeout),
    .strobe     (strobe)
  );

  adcrd_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .startCfg    (startCfg),
    .sdo         (sdo),
    .resReady    (resReady),
    .sdi         (sdi),
    .resValid    (resValid),
    .resData     (resData),
    .resSign     (resSign),
    .resCfg      (resCfg),
    .resFrameErr (resFrameErr)
  );

endmodule

// File: tb/adc_readout_host_tb.sv
module adc_readout_host_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 1'b0;
  logic startReady;
  logic [5:0] startCfg = '0;
  logic [7:0] halfDiv = 8'd1;
  logic [15:0] pollLimit = 16'd1000;
  logic csN, sck, sdi, sdo;
  logic resValid;
  logic resReady = 1'b0;
  logic [20:0] resData;
  logic resSign;
  logic [5:0] resCfg;
  logic resFrameErr;
  logic errTimeout;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  adc_readout_host u_dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startReady(startReady),
    .startCfg(startCfg), .halfDiv(halfDiv), .pollLimit(pollLimit),
    .csN(csN), .sck(sck), .sdi(sdi), .sdo(sdo), .resValid(resValid),
    .resReady(resReady), .resData(resData), .resSign(resSign),
    .resCfg(resCfg), .resFrameErr(resFrameErr), .errTimeout(errTimeout)
  );

  // ---------------- converter model ----------------
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [23:0] mkFrame(input logic [5:0] c, input int seq, input logic bad);
    logic [20:0] d;
    d = {c, seq[14:0]};
    return {1'b0, bad, c[0] ^ seq[0], d};
  endfunction

  int convEnd = 0;
  int convCycles = 30;
  logic badNext = 1'b0;
  logic dataMode = 1'b0;
  int bitIdx = 0;
  int modelSeq = 1;
  int riseCnt = 0;
  int earlyClk = 0;
  int csFallBad = 0;
  int sckOutside = 0;
  logic [23:0] frame = 24'(0);
  logic [23:0] cfgIn = '0;
  logic done;

  assign done = (cyc >= convEnd);
  assign sdo = csN ? 1'b1 : (dataMode ? frame[23 - bitIdx] : ~done);

  always @(sck) begin
    if (rstN && !csN) begin
      if (sck) begin
        if (!dataMode) begin
          if (done) begin dataMode = 1'b1; bitIdx = 0; end
          else earlyClk++;
        end
        if (dataMode) begin cfgIn = {cfgIn[22:0], sdi}; riseCnt++; end
      end else if (dataMode) begin
        bitIdx++;
        if (bitIdx == 24) begin
          dataMode = 1'b0;
          bitIdx = 0;
          frame = mkFrame(cfgIn[21:16], modelSeq, badNext);
          modelSeq++;
          convEnd = cyc + convCycles;
        end
      end
    end
  end

  always @(negedge csN) if (rstN && sck) csFallBad++;
  always @(posedge sck) if (rstN && csN) sckOutside++;

  // ---------------- checking helpers ----------------
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [23:0] expFrame = 24'(0);
  logic [5:0]  expCfg = '0;
  int          expSeq = 1;

  // One transfer; returns after result is consumed or timeout seen
  task automatic doXfer(input logic [5:0] cfg, input logic expTimeout,
                        input int holdCycles, input logic bad);
    int csLow = 0;
    int runLen = 0;
    int badRun = 0;
    logic prevSck = 1'b0;
    logic riseSeen = 1'b0;
    logic sawTimeout = 1'b0;
    int riseStart;
    int eff;
    eff = (halfDiv == 0) ? 1 : int'(halfDiv);
    badNext = bad;
    @(negedge clk);
    while (!startReady) @(negedge clk);
    startValid = 1'b1;
    startCfg = cfg;
    riseStart = riseCnt;
    @(negedge clk);
    startValid = 1'b0;
    while (!resValid && !sawTimeout) begin
      if (errTimeout) sawTimeout = 1'b1;
      if (!csN) csLow++;
      if (sck != prevSck) begin
        if (prevSck || riseSeen) if (runLen != eff) badRun++;
        if (sck) riseSeen = 1'b1;
        runLen = 0;
      end
      runLen++;
      prevSck = sck;
      if (!sawTimeout) @(negedge clk);
    end
    if (expTimeout) begin
      check("R3 timeout pulse", 32'(sawTimeout), 32'd1);
      check("R3 cycles low before release", 32'(csLow), 32'((pollLimit == 0) ? 1 : pollLimit));
      check("R3 no clocking", 32'(riseCnt - riseStart), 32'd0);
      @(negedge clk);
      check("R3 chip select released", 32'(csN), 32'd1);
      check("R3 no result", 32'(resValid), 32'd0);
      return;
    end
    check("R3 no unexpected timeout", 32'(sawTimeout), 32'd0);
    check("R9 cs high with valid", 32'(csN), 32'd1);
    check("R4 phase lengths", 32'(badRun), 32'd0);
    check("R5 rising edges", 32'(riseCnt - riseStart), 32'd24);
    check("R5 command bits", 32'(cfgIn), {8'h0, 2'b10, cfg, 16'h0});
    check("R6 data", 32'(resData), 32'(expFrame[20:0]));
    check("R6 sign", 32'(resSign), 32'(expFrame[21]));
    check("R7 config tag", 32'(resCfg), 32'(expCfg));
    check("R8 frame error", 32'(resFrameErr), 32'(expFrame[23] | expFrame[22]));
    for (int i = 0; i < holdCycles; i++) begin
      @(negedge clk);
      check("R10 valid held", 32'(resValid), 32'd1);
      check("R10 start blocked", 32'(startReady), 32'd0);
    end
    resReady = 1'b1;
    @(negedge clk);
    resReady = 1'b0;
    check("R10 valid cleared", 32'(resValid), 32'd0);
    expFrame = mkFrame(cfg, expSeq, bad);
    expSeq++;
    expCfg = cfg;
  endtask

  // ---------------- main sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    check("R1 csN", 32'(csN), 32'd1);
    check("R1 sck", 32'(sck), 32'd0);
    check("R1 resValid", 32'(resValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 startReady", 32'(startReady), 32'd1);

    for (int d = 0; d < 4; d++) begin
      halfDiv = 8'(d);
      for (int c = 0; c < 64; c++) begin
        doXfer(6'(c), 1'b0, (c % 7 == 0) ? 3 : 0, (c == 13 && d == 2));
      end
    end

    // R3 / R7: timeout while converter busy, then recover
    halfDiv = 8'd2;
    convCycles = 4000;
    doXfer(6'h2A, 1'b0, 0, 1'b0);
    pollLimit = 16'd20;
    doXfer(6'h15, 1'b1, 0, 1'b0);
    pollLimit = 16'd0;
    doXfer(6'h07, 1'b1, 0, 1'b0);
    pollLimit = 16'd10000;
    convCycles = 30;
    doXfer(6'h31, 1'b0, 1, 1'b0);
    doXfer(6'h0C, 1'b0, 0, 1'b0);

    check("R2 cs fell with sck high", 32'(csFallBad), 32'd0);
    check("R2 sck high with cs high", 32'(sckOutside), 32'd0);
    check("R3 clock while busy", 32'(earlyClk), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule